// File: doc/BRIEF.md
# Three-stage RV32 integer subset core

This block is a small in-order processor that runs a subset of the 32-bit RISC-V integer instructions and three of the multiply instructions. It covers register-register arithmetic and logic, register-immediate arithmetic and shifts, and upper-immediate loads. It also has one CSR swap instruction, which is its only path to the outside world. Every instruction runs through three stages. Fetch presents the program counter to a synchronous instruction memory. Execute decodes the returned word, reads the register file and computes the result. Writeback commits the result to the register file one cycle later. A dependent instruction in execute picks up the value in writeback through the register file's write bypass, so the pipeline never stalls.

The instruction memory is a parameterised array of 32-bit words. The surrounding environment (the testbench here) preloads it. The program counter counts words, advances every cycle and wraps to zero. A small pipeline controller has two states. ST_PRIME is the single cycle after reset, when the memory has not yet returned a word and execute holds a bubble. ST_RUN is normal operation. The transition ST_PRIME to ST_RUN happens unconditionally on the first clock edge after reset, and ST_RUN loops on itself. Reset returns the controller to ST_PRIME from either state.

CSR 0xF00 returns the `io_in` port. CSR 0xF01 returns a fixed auxiliary input word set by a parameter. A swap into CSR 0xF02 loads the `io_out` register. CSR 0xF03 accepts writes but has no outlet in this block.

Top module: `tri_stage_core`

## Requirements
- R1: Reset (active-high `rst`, synchronous) clears `io_out`, all 32 registers and the PC to 0. On the first edge after reset the controller moves from ST_PRIME to ST_RUN. The word fetched for that edge produces no register write and no `io_out` change.
- R2: The PC starts at word 0, adds one each cycle and wraps from IMEM_DEPTH-1 to 0. The instruction stored at word k changes `io_out` (if it writes CSR 0xF02) on the (k+2)-th rising edge after reset is released. After a wrap, the program runs again from word 0.
- R3: Opcode 0110011 with funct7 0000000 selects, by funct3, add (000), sll (001), slt (010), sltu (011), xor (100), srl (101), or (110) and and (111). With funct7 0100000, funct3 000 is sub and funct3 101 is sra. Register shifts use the low 5 bits of rs2.
- R4: Opcode 0110011 with funct7 0000001 selects mul (funct3 000, low 32 bits of the product), mulh (001, high 32 bits of the signed product) and mulhu (011, high 32 bits of the unsigned product).
- R5: Opcode 0010011 with funct3 000/100/110/111 performs addi/xori/ori/andi. The immediate is bits 31:20, sign-extended from bit 31.
- R6: Opcode 0010011 with funct3 001 and bits 31:25 = 0000000 is slli. With funct3 101, bits 31:25 = 0000000 is srli and 0100000 is srai. The shift amount is bits 24:20.
- R7: Opcode 0110111 (lui) writes {bits 31:12, 12'b0} to rd.
- R8: Opcode 1110011 with funct3 001 is a CSR swap on the CSR number in bits 31:20. rd receives the old CSR value: 0xF00 returns `io_in` and 0xF01 returns AUX_INPUT. Writing 0xF02 loads rs1 into `io_out`, and the new value is seen on the same edge on which rd is scheduled.
- R9: Reading 0xF02, 0xF03 or any unknown CSR number returns 0. Writing 0xF00, 0xF01 or an unknown number leaves `io_out` unchanged. `io_out` changes only on a swap to 0xF02 or on reset.
- R10: An instruction that reads a register written by the instruction just before it sees the new value. The same holds two or more instructions later.
- R11: Any other encoding is a no-op that writes no register and no CSR. Examples are funct7 0000001 with funct3 100, slti (0010011/010), a CSR opcode with funct3 other than 001, and a shift-immediate with bad bits 31:25.
- R12: A write to register 0 never changes it, so register 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| io_in | input | 32 | General input, read through CSR 0xF00 |
| io_out | output | 32 | General output register, written through CSR 0xF02 |

## Verification
The only window into the core is `io_out`, so every register and ALU result must be routed there by a CSR swap before it can be seen. The test program therefore follows each computation at once with a swap to 0xF02.

A wrong ALU result, decode, immediate extension or bypass then shows as a mismatch on the edge where that swap commits, two edges after the swap is fetched. A wrong PC step or a missing priming bubble shifts every later update by a cycle, so the per-cycle comparison catches it on the first output change. A register that ought to stay untouched (x0, or the target of a no-op) is read back and emitted straight after the suspect instruction.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int XLEN     = 32;
    localparam int REG_CNT  = 32;
    localparam int RA_W     = $clog2(REG_CNT);
    localparam int CSR_W    = 12;

    localparam logic [6:0] OPC_REG  = 7'b0110011;
    localparam logic [6:0] OPC_IMM  = 7'b0010011;
    localparam logic [6:0] OPC_LUI  = 7'b0110111;
    localparam logic [6:0] OPC_SYS  = 7'b1110011;

    localparam logic [6:0] F7_BASE  = 7'b0000000;
    localparam logic [6:0] F7_ALT   = 7'b0100000;
    localparam logic [6:0] F7_MULT  = 7'b0000001;

    localparam logic [CSR_W-1:0] CSR_IN_MAIN  = 12'hF00;
    localparam logic [CSR_W-1:0] CSR_IN_AUX   = 12'hF01;
    localparam logic [CSR_W-1:0] CSR_OUT_MAIN = 12'hF02;

    typedef enum logic [3:0] {
        ALU_AND, ALU_OR, ALU_XOR, ALU_ADD, ALU_SUB,
        ALU_MUL, ALU_MULH, ALU_MULHU,
        ALU_SLL, ALU_SRL, ALU_SRA, ALU_SLT, ALU_SLTU
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU, WB_UPPER, WB_CSR
    } wb_src_e;

    typedef enum logic {
        ST_PRIME, ST_RUN
    } pipe_state_e;

    typedef struct packed {
        logic    legal;
        logic    reg_we;
        logic    use_imm;
        logic    csr_op;
        alu_op_e alu_op;
        wb_src_e wb_src;
    } ctrl_t;

endpackage

// File: rtl/tsc_imem.sv
module tsc_imem #(
    parameter int          DEPTH = 4096,
    parameter int          W     = 32,
    parameter logic [31:0] FILL  = 32'h0000_0013
) (
    input  logic                     clk,
    input  logic [$clog2(DEPTH)-1:0] addr,
    output logic [W-1:0]             data
);
    logic [W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = W'(FILL);
    end

    always_ff @(posedge clk) begin
        data <= mem[addr];
    end
endmodule

// File: rtl/tsc_regfile.sv
module tsc_regfile #(
    parameter int W      = 32,
    parameter int N      = 32,
    parameter int NPORTS = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NPORTS-1:0][$clog2(N)-1:0]    raddr,
    output logic [NPORTS-1:0][W-1:0]            rdata,
    input  logic                                we,
    input  logic [$clog2(N)-1:0]                waddr,
    input  logic [W-1:0]                        wdata
);
    localparam int AW = $clog2(N);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        always_comb begin
            if (raddr[p] == AW'(0))
                rdata[p] = '0;
            else if (we && waddr == raddr[p])
                rdata[p] = wdata;
            else
                rdata[p] = regs[raddr[p]];
        end
    end
endmodule

// File: rtl/tsc_alu.sv
module tsc_alu
    import tsc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int SH_W = $clog2(W);

    logic             sgn;
    logic [2*W-1:0]   ext_a, ext_b, prod;
    logic [SH_W-1:0]  sh;

    always_comb begin
        sgn   = (op == ALU_MULH);
        ext_a = {{W{a[W-1] & sgn}}, a};
        ext_b = {{W{b[W-1] & sgn}}, b};
        prod  = ext_a * ext_b;
        sh    = b[SH_W-1:0];
        case (op)
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_XOR:   y = a ^ b;
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_MUL:   y = prod[W-1:0];
            ALU_MULH:  y = prod[2*W-1:W];
            ALU_MULHU: y = prod[2*W-1:W];
            ALU_SLL:   y = a << sh;
            ALU_SRL:   y = a >> sh;
            ALU_SRA:   y = W'($signed(a) >>> sh);
            ALU_SLT:   y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
            ALU_SLTU:  y = {{(W-1){1'b0}}, a < b};
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
    import tsc_pkg::*;
(
    input  logic [6:0]       opcode,
    input  logic [2:0]       funct3,
    input  logic [6:0]       funct7,
    input  logic [RA_W-1:0]  rd,
    output ctrl_t            ctl
);
    always_comb begin
        ctl        = '0;
        ctl.alu_op = ALU_ADD;
        ctl.wb_src = WB_ALU;
        case (opcode)
            OPC_REG: begin
                ctl.legal = 1'b1;
                case ({funct7, funct3})
                    {F7_BASE, 3'b000}: ctl.alu_op = ALU_ADD;
                    {F7_BASE, 3'b001}: ctl.alu_op = ALU_SLL;
                    {F7_BASE, 3'b010}: ctl.alu_op = ALU_SLT;
                    {F7_BASE, 3'b011}: ctl.alu_op = ALU_SLTU;
                    {F7_BASE, 3'b100}: ctl.alu_op = ALU_XOR;
                    {F7_BASE, 3'b101}: ctl.alu_op = ALU_SRL;
                    {F7_BASE, 3'b110}: ctl.alu_op = ALU_OR;
                    {F7_BASE, 3'b111}: ctl.alu_op = ALU_AND;
                    {F7_ALT,  3'b000}: ctl.alu_op = ALU_SUB;
                    {F7_ALT,  3'b101}: ctl.alu_op = ALU_SRA;
                    {F7_MULT, 3'b000}: ctl.alu_op = ALU_MUL;
                    {F7_MULT, 3'b001}: ctl.alu_op = ALU_MULH;
                    {F7_MULT, 3'b011}: ctl.alu_op = ALU_MULHU;
                    default:           ctl.legal  = 1'b0;
                endcase
            end
            OPC_IMM: begin
                ctl.legal   = 1'b1;
                ctl.use_imm = 1'b1;
                case (funct3)
                    3'b000: ctl.alu_op = ALU_ADD;
                    3'b100: ctl.alu_op = ALU_XOR;
                    3'b110: ctl.alu_op = ALU_OR;
                    3'b111: ctl.alu_op = ALU_AND;
                    3'b001: begin
                        ctl.alu_op = ALU_SLL;
                        ctl.legal  = (funct7 == F7_BASE);
                    end
                    3'b101: begin
                        ctl.alu_op = (funct7 == F7_ALT) ? ALU_SRA : ALU_SRL;
                        ctl.legal  = (funct7 == F7_BASE) || (funct7 == F7_ALT);
                    end
                    default: ctl.legal = 1'b0;
                endcase
            end
            OPC_LUI: begin
                ctl.legal  = 1'b1;
                ctl.wb_src = WB_UPPER;
            end
            OPC_SYS: begin
                ctl.csr_op = 1'b1;
                ctl.legal  = (funct3 == 3'b001);
                ctl.wb_src = WB_CSR;
            end
            default: ctl.legal = 1'b0;
        endcase
        ctl.reg_we = ctl.legal && (rd != '0);
    end
endmodule

// File: rtl/tri_stage_core.sv
module tri_stage_core
    import tsc_pkg::*;
#(
    parameter int          IMEM_DEPTH = 4096,
    parameter logic [31:0] AUX_INPUT  = 32'h0000_5A5A
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] io_in,
    output logic [31:0] io_out
);
    localparam int PC_W = $clog2(IMEM_DEPTH);

    // pipeline controller
    pipe_state_e state_q, state_d;
    logic        ex_valid;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PRIME;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        ex_valid = (state_q == ST_RUN);
    end

    // fetch stage
    logic [PC_W-1:0] pc_q;
    logic [XLEN-1:0] instr_ex;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_q + 1'b1;
    end

    tsc_imem #(.DEPTH(IMEM_DEPTH), .W(XLEN)) u_imem (
        .clk  (clk),
        .addr (pc_q),
        .data (instr_ex)
    );

    // execute stage
    logic [RA_W-1:0]  rd_ex;
    logic [CSR_W-1:0] csr_ex;
    logic [XLEN-1:0]  imm_ex, upper_ex, opb_ex, alu_y, csr_rd_val, wb_data_d;
    ctrl_t            ctl_ex;
    logic [1:0][RA_W-1:0] rf_raddr;
    logic [1:0][XLEN-1:0] rf_rdata;
    logic             out_we;

    logic             wb_we_q;
    logic [RA_W-1:0]  wb_rd_q;
    logic [XLEN-1:0]  wb_data_q;
    logic [XLEN-1:0]  out_q;

    assign rd_ex       = instr_ex[11:7];
    assign csr_ex      = instr_ex[31:20];
    assign imm_ex      = {{(XLEN-12){instr_ex[31]}}, instr_ex[31:20]};
    assign upper_ex    = {instr_ex[31:12], 12'b0};
    assign rf_raddr[0] = instr_ex[19:15];
    assign rf_raddr[1] = instr_ex[24:20];

    tsc_ctrl u_ctrl (
        .opcode (instr_ex[6:0]),
        .funct3 (instr_ex[14:12]),
        .funct7 (instr_ex[31:25]),
        .rd     (rd_ex),
        .ctl    (ctl_ex)
    );

    tsc_regfile #(.W(XLEN), .N(REG_CNT), .NPORTS(2)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .raddr (rf_raddr),
        .rdata (rf_rdata),
        .we    (wb_we_q),
        .waddr (wb_rd_q),
        .wdata (wb_data_q)
    );

    assign opb_ex = ctl_ex.use_imm ? imm_ex : rf_rdata[1];

    tsc_alu #(.W(XLEN)) u_alu (
        .op (ctl_ex.alu_op),
        .a  (rf_rdata[0]),
        .b  (opb_ex),
        .y  (alu_y)
    );

    always_comb begin
        case (csr_ex)
            CSR_IN_MAIN: csr_rd_val = io_in;
            CSR_IN_AUX:  csr_rd_val = AUX_INPUT;
            default:     csr_rd_val = '0;
        endcase
        case (ctl_ex.wb_src)
            WB_UPPER: wb_data_d = upper_ex;
            WB_CSR:   wb_data_d = csr_rd_val;
            default:  wb_data_d = alu_y;
        endcase
    end

    assign out_we = ex_valid && ctl_ex.legal && ctl_ex.csr_op && (csr_ex == CSR_OUT_MAIN);

    // execute/writeback boundary and output register
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_we_q   <= 1'b0;
            wb_rd_q   <= '0;
            wb_data_q <= '0;
            out_q     <= '0;
        end else begin
            wb_we_q   <= ex_valid && ctl_ex.reg_we;
            wb_rd_q   <= rd_ex;
            wb_data_q <= wb_data_d;
            if (out_we) out_q <= rf_rdata[0];
        end
    end

    assign io_out = out_q;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int PC_W = 12
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] pc,
    input logic            ex_valid,
    input logic            ex_legal,
    input logic            wb_we,
    input logic [4:0]      wb_rd,
    input logic [31:0]     wb_data,
    input logic [4:0]      rs1_addr,
    input logic [31:0]     rs1_data,
    input logic            out_we,
    input logic [31:0]     io_out
);
    AST_PRIME_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        !ex_valid |=> (!wb_we && $stable(io_out)));                      // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pc == $past(pc) + 1'b1);                         // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_we |=> $stable(io_out));                                    // R9

    AST_BYPASS_FWD: assert property (@(posedge clk) disable iff (rst)
        (wb_we && rs1_addr == wb_rd) |-> rs1_data == wb_data);           // R10

    AST_NOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !ex_legal) |=> (!wb_we && $stable(io_out)));        // R11

    AST_ZERO_REG_KEEP: assert property (@(posedge clk) disable iff (rst)
        wb_we |-> wb_rd != 5'd0);                                        // R12
endmodule

bind tri_stage_core tsc_checker #(.PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (pc_q),
    .ex_valid (ex_valid),
    .ex_legal (ctl_ex.legal),
    .wb_we    (wb_we_q),
    .wb_rd    (wb_rd_q),
    .wb_data  (wb_data_q),
    .rs1_addr (rf_raddr[0]),
    .rs1_data (rf_rdata[0]),
    .out_we   (out_we),
    .io_out   (io_out)
);

// File: tb/tri_stage_core_bench.sv
module tri_stage_core_bench;
    localparam int          DEPTH   = 4096;
    localparam logic [31:0] AUX_VAL = 32'h0000_5A5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] io_in = 32'h0;
    logic [31:0] io_out;

    always #10 clk = ~clk;

    tri_stage_core #(.IMEM_DEPTH(DEPTH), .AUX_INPUT(AUX_VAL)) u_tri_stage_core (
        .clk    (clk),
        .rst    (rst),
        .io_in  (io_in),
        .io_out (io_out)
    );

    logic [31:0] prog [DEPTH];
    string       tags [DEPTH];
    int          bp;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // reference state
    logic [31:0] m_regs [32];
    logic [31:0] m_out;
    bit          m_valid;
    int          m_idx;
    string       cur_tag = "R1";

    function automatic logic [31:0] f_r(input logic [6:0] f7, input int rs2, input int rs1,
                                        input logic [2:0] f3, input int rd);
        return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
    endfunction

    function automatic logic [31:0] f_i(input logic [11:0] imm, input int rs1, input logic [2:0] f3,
                                        input int rd, input logic [6:0] op);
        return {imm, 5'(rs1), f3, 5'(rd), op};
    endfunction

    function automatic logic [31:0] f_lui(input logic [19:0] up, input int rd);
        return {up, 5'(rd), 7'b0110111};
    endfunction

    function automatic logic [31:0] f_csr(input logic [11:0] num, input int rs1, input int rd);
        return f_i(num, rs1, 3'b001, rd, 7'b1110011);
    endfunction

    task automatic put(input logic [31:0] w, input string t);
        prog[bp] = w;
        tags[bp] = t;
        bp++;
    endtask

    task automatic put_emit(input logic [31:0] w, input int rd, input string t);
        put(w, t);
        put(f_csr(12'hF02, rd, 0), t);
    endtask

    task automatic model_exec(input logic [31:0] w);
        logic [6:0]  op, f7;
        logic [2:0]  f3;
        logic [4:0]  rd, r1, r2, sa;
        logic [31:0] a, b, imm, res;
        logic signed [63:0] ps;
        logic [63:0] pu;
        bit ok;
        op = w[6:0]; f3 = w[14:12]; f7 = w[31:25];
        rd = w[11:7]; r1 = w[19:15]; r2 = w[24:20]; sa = w[24:20];
        a = m_regs[r1]; b = m_regs[r2];
        imm = {{20{w[31]}}, w[31:20]};
        ps = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        pu = {32'b0, a} * {32'b0, b};
        ok = 1'b0; res = 32'h0;
        if (op == 7'b0110011) begin
            ok = 1'b1;
            if (f7 == 7'b0000000) begin
                case (f3)
                    3'd0: res = a + b;
                    3'd1: res = a << b[4:0];
                    3'd2: res = {31'b0, $signed(a) < $signed(b)};
                    3'd3: res = {31'b0, a < b};
                    3'd4: res = a ^ b;
                    3'd5: res = a >> b[4:0];
                    3'd6: res = a | b;
                    default: res = a & b;
                endcase
            end
            else if (f7 == 7'b0100000 && f3 == 3'd0) res = a - b;
            else if (f7 == 7'b0100000 && f3 == 3'd5) res = $signed(a) >>> b[4:0];
            else if (f7 == 7'b0000001 && f3 == 3'd0) res = ps[31:0];
            else if (f7 == 7'b0000001 && f3 == 3'd1) res = ps[63:32];
            else if (f7 == 7'b0000001 && f3 == 3'd3) res = pu[63:32];
            else ok = 1'b0;
        end else if (op == 7'b0010011) begin
            ok = 1'b1;
            case (f3)
                3'd0: res = a + imm;
                3'd4: res = a ^ imm;
                3'd6: res = a | imm;
                3'd7: res = a & imm;
                3'd1: if (f7 == 7'b0000000) res = a << sa; else ok = 1'b0;
                3'd5: if (f7 == 7'b0000000) res = a >> sa;
                      else if (f7 == 7'b0100000) res = $signed(a) >>> sa;
                      else ok = 1'b0;
                default: ok = 1'b0;
            endcase
        end else if (op == 7'b0110111) begin
            ok = 1'b1;
            res = {w[31:12], 12'b0};
        end else if (op == 7'b1110011 && f3 == 3'b001) begin
            ok = 1'b1;
            case (w[31:20])
                12'hF00: res = io_in;
                12'hF01: res = AUX_VAL;
                default: res = 32'h0;
            endcase
            if (w[31:20] == 12'hF02) m_out = a;
        end
        if (ok && rd != 5'd0) m_regs[rd] = res;
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) m_regs[i] = 32'h0;
            m_out   = 32'h0;
            m_valid = 1'b0;
            m_idx   = 0;
            cur_tag = "R1";
        end else begin
            if (m_valid) begin
                model_exec(prog[m_idx]);
                cur_tag = tags[m_idx];
                m_idx   = (m_idx + 1) % DEPTH;
            end
            m_valid = 1'b1;
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (io_out !== m_out) begin
                misses++;
                $display("FAIL %s: io_out=%h expected %h at %0t", cur_tag, io_out, m_out, $time);
            end
        end
    end

    initial begin
        bp = 0;
        // R5 immediates and sign extension; R10 emit straight after the write
        put_emit(f_i(12'h123, 0, 3'b000, 1, 7'b0010011), 1, "R10");
        put_emit(f_i(12'hFFB, 0, 3'b000, 2, 7'b0010011), 2, "R5");
        // R7 upper immediate
        put_emit(f_lui(20'h80000, 3), 3, "R7");
        put_emit(f_i(12'hFFF, 3, 3'b000, 3, 7'b0010011), 3, "R5");
        // R3 register-register
        put_emit(f_r(7'b0000000, 2, 1, 3'b000, 4), 4, "R3");
        put_emit(f_r(7'b0100000, 2, 1, 3'b000, 4), 4, "R3");
        put_emit(f_r(7'b0000000, 2, 1, 3'b111, 4), 4, "R3");
        put_emit(f_r(7'b0000000, 2, 1, 3'b110, 4), 4, "R3");
        put_emit(f_r(7'b0000000, 2, 1, 3'b100, 4), 4, "R3");
        put_emit(f_r(7'b0000000, 1, 2, 3'b001, 4), 4, "R3");
        put_emit(f_r(7'b0000000, 1, 2, 3'b101, 4), 4, "R3");
        put_emit(f_r(7'b0100000, 1, 2, 3'b101, 4), 4, "R3");
        put_emit(f_r(7'b0000000, 1, 2, 3'b010, 4), 4, "R3");
        put_emit(f_r(7'b0000000, 1, 2, 3'b011, 4), 4, "R3");
        put_emit(f_r(7'b0000000, 2, 1, 3'b010, 4), 4, "R3");
        // R4 multiplies
        put_emit(f_r(7'b0000001, 3, 2, 3'b000, 4), 4, "R4");
        put_emit(f_r(7'b0000001, 3, 2, 3'b001, 4), 4, "R4");
        put_emit(f_r(7'b0000001, 3, 2, 3'b011, 4), 4, "R4");
        put_emit(f_r(7'b0000001, 2, 2, 3'b001, 4), 4, "R4");
        // R5 logic immediates with negative constants
        put_emit(f_i(12'h8F0, 1, 3'b111, 5, 7'b0010011), 5, "R5");
        put_emit(f_i(12'h80F, 1, 3'b110, 5, 7'b0010011), 5, "R5");
        put_emit(f_i(12'hF0F, 1, 3'b100, 5, 7'b0010011), 5, "R5");
        // R6 immediate shifts
        put_emit(f_i(12'h004, 2, 3'b001, 6, 7'b0010011), 6, "R6");
        put_emit(f_i(12'h01F, 2, 3'b101, 6, 7'b0010011), 6, "R6");
        put_emit(f_i(12'h41F, 2, 3'b101, 6, 7'b0010011), 6, "R6");
        put_emit(f_i(12'h408, 3, 3'b101, 6, 7'b0010011), 6, "R6");
        // R8 CSR reads and output write
        put_emit(f_csr(12'hF00, 0, 7), 7, "R8");
        put_emit(f_csr(12'hF01, 0, 7), 7, "R8");
        put(f_csr(12'hF02, 1, 8), "R8");
        put(f_csr(12'hF02, 5, 8), "R8");
        // R9 write-only / unknown reads give 0, writes to inputs ignored
        put(f_csr(12'hF02, 8, 0), "R9");
        put(f_csr(12'hF00, 2, 9), "R9");
        put(f_csr(12'h123, 2, 9), "R9");
        put(f_csr(12'hF03, 2, 0), "R9");
        put(f_csr(12'hF01, 3, 0), "R9");
        put_emit(f_csr(12'hF03, 1, 9), 9, "R9");
        put_emit(f_csr(12'h7C0, 1, 9), 9, "R9");
        // R10 chained dependencies, one and two apart
        put(f_r(7'b0000000, 1, 1, 3'b000, 11), "R10");
        put(f_i(12'h001, 11, 3'b000, 11, 7'b0010011), "R10");
        put(f_i(12'h010, 0, 3'b000, 12, 7'b0010011), "R10");
        put_emit(f_r(7'b0000000, 11, 11, 3'b000, 11), 11, "R10");
        put_emit(f_r(7'b0100000, 12, 11, 3'b000, 13), 13, "R10");
        // R11 unsupported encodings leave x4 alone
        put_emit(f_i(12'h321, 0, 3'b000, 4, 7'b0010011), 4, "R11");
        put_emit(f_r(7'b0000001, 2, 1, 3'b100, 4), 4, "R11");
        put_emit(f_i(12'h7FF, 1, 3'b010, 4, 7'b0010011), 4, "R11");
        put_emit(f_i(12'h404, 1, 3'b001, 4, 7'b0010011), 4, "R11");
        put_emit(f_r(7'b0100000, 2, 1, 3'b001, 4), 4, "R11");
        put_emit(f_i(12'hF00, 0, 3'b010, 4, 7'b1110011), 4, "R11");
        put(f_i(12'hF02, 2, 3'b010, 0, 7'b1110011), "R11");
        put_emit(f_i(12'h000, 1, 3'b010, 4, 7'b0000011), 4, "R11");
        // R12 register 0 stays zero
        put_emit(f_i(12'h055, 0, 3'b000, 0, 7'b0010011), 0, "R12");
        put_emit(f_r(7'b0000000, 1, 1, 3'b000, 0), 0, "R12");
        put_emit(f_lui(20'hABCDE, 0), 0, "R12");
        put_emit(f_csr(12'hF00, 0, 0), 0, "R12");
        put_emit(f_r(7'b0000000, 0, 1, 3'b000, 14), 14, "R12");
        // R2 fill and wrap marker
        for (int i = bp; i < DEPTH; i++) begin
            prog[i] = 32'h0000_0013;
            tags[i] = "R2";
        end
        prog[DEPTH-2] = f_i(12'h7AB, 0, 3'b000, 10, 7'b0010011);
        prog[DEPTH-1] = f_csr(12'hF02, 10, 0);
    end

    initial begin
        #1;
        for (int i = 0; i < DEPTH; i++) u_tri_stage_core.u_imem.mem[i] = prog[i];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < DEPTH + 200; c++) begin
            @(negedge clk);
            if (c % 13 == 0) io_in = 32'h9E37_79B9 * (c + 1);
        end
        // mid-run reset, R1
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (120) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL R2: watchdog expired, io_out=%h expected completion", io_out);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule